// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-interface master of an Ethernet subsystem. Software sets up two 16-bit holding registers through a small register bus: the register or extended address, and the value to write. It then writes a command word. A command word with its start bit set launches one management frame on the MDC clock and the bidirectional MDIO line. The ST field of the command chooses between the short (Clause 22) frame form and the extended (Clause 45) frame form. The operation field is placed on the wire unchanged.

For a read, the master releases MDIO at the turnaround and shifts in 16 bits from the PHY. At the end of the frame, those bits land in a read-data register. A status flag records whether the PHY failed to pull the second turnaround bit low, which marks the read data as unusable. Software polls the start bit, which stays at 1 for the whole frame, before it issues the next command.

The register bus has no back-pressure: every write or read strobe is taken in the cycle it is presented, and read data appears one cycle later. MDC runs only while a frame is in progress. It is the system clock divided by an even ratio.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, MDIO is not driven (`mdio_oe` = 0), and every register reads 0. While no frame is in progress, MDC stays low and MDIO stays released.
- R2: A write to offset 0x4 sets the address value and a write to offset 0x8 sets the write-data value. Both read back at the same offsets. Reads return their contents one cycle after the read strobe.
- R3: A write to offset 0x0 is accepted only while no frame is in progress. The offset 0x0 layout is: bits 4:0 device or register number, bits 9:5 port address, bits 11:10 operation, bits 13:12 ST, bit 14 start. With bit 14 set, the write starts a frame of exactly 64 MDC periods, and bit 14 reads back 1 until the frame ends and 0 afterwards. Without bit 14 set, the fields are stored and no frame starts.
- R4: While a frame runs, MDC is the clock divided by DIV. MDC is high for DIV/2 cycles and low for DIV/2 cycles, and the first half-period of each bit is low.
- R5: The frame bit order is: 32 ones, then command bits 13:12, 11:10, 9:5 and 4:0 (most significant bit first), then two turnaround bits, then a 16-bit field sent most significant bit first. The master changes MDIO only on the falling edge of MDC.
- R6: The field after the turnaround carries the address value when ST=0 and operation=0. Every other frame that is not a read carries the write-data value. A frame that is not a read drives the turnaround as 1 then 0.
- R7: A frame is a read when ST=1 with operation 2, or ST=0 with operation 2 or 3. For a read, the master releases MDIO from the first turnaround bit to the end of the frame.
- R8: On a read, the master samples the 16 bits after the turnaround at the rising edges of MDC, first bit as most significant. It places them in the register at offset 0xC when the frame ends.
- R9: Bit 0 at offset 0x10 is 1 when the second turnaround bit of the most recent read was not low. A read frame whose turnaround is good clears it. Frames that are not reads leave it unchanged.
- R10: A command write that arrives while a frame runs is ignored. The running frame, the stored fields and the frame length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write value |
| bus_rdata | output | 16 | Read value, valid the cycle after `bus_rd` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Value the master drives on MDIO |
| mdio_oe | output | 1 | 1 when the master drives MDIO |
| mdio_i | input | 1 | Sensed level of the MDIO line |

## Verification
The bench builds the block with DIV=4. This gives a two-cycle half-period that exercises the divider counter wrap while keeping each frame at 256 clocks. That is short enough to run write, extended-address, short-read, extended-read and failed-turnaround frames back to back. A responder that answers on MDC falling edges, together with a pull-up on the released line, makes both the good turnaround and the missing turnaround reachable.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;

  // byte offsets of the software-visible registers
  localparam logic [ADDR_W-1:0] OFS_CMD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_ADR = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_WDT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RDT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STS = 5'h10;

  localparam int GO_BIT = 14;

  localparam logic [1:0] ST_EXT   = 2'd0;  // extended frame form
  localparam logic [1:0] ST_SHORT = 2'd1;  // short frame form
  localparam logic [1:0] OP_SHORT_RD = 2'd2;
  localparam logic [1:0] OP_EXT_ADR  = 2'd0;

  // bit positions within the 64-bit frame
  localparam int TA_HI_IDX = 46;
  localparam int TA_LO_IDX = 47;
  localparam int DAT_IDX   = 48;

  typedef struct packed {
    logic [1:0] st;
    logic [1:0] op;
    logic [4:0] port;
    logic [4:0] dev;
  } cmd_t;

  function automatic logic frame_is_read(cmd_t c);
    return (c.st == ST_SHORT && c.op == OP_SHORT_RD) || (c.st == ST_EXT && c.op[1]);
  endfunction

  function automatic logic frame_sends_addr(cmd_t c);
    return (c.st == ST_EXT) && (c.op == OP_EXT_ADR);
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic tick;

  generate
    if (HALF > 1) begin : g_cnt
      logic [CW-1:0] cnt;
      assign tick = (cnt == CW'(HALF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
      end
    end else begin : g_nocnt
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mdc <= 1'b0;
    else if (!run)   mdc <= 1'b0;
    else if (tick)   mdc <= ~mdc;
  end

  assign rise_tk = run && tick && !mdc;
  assign fall_tk = run && tick && mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  is_read,
  input  logic                  rise_tk,
  input  logic                  fall_tk,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  rd_done,
  output logic [DATA_W-1:0]     rd_word,
  output logic                  ta_bad
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST  = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] TA_HI = IW'(TA_HI_IDX);
  localparam logic [IW-1:0] TA_LO = IW'(TA_LO_IDX);
  localparam logic [IW-1:0] DAT0  = IW'(DAT_IDX);

  logic [IW-1:0]         idx;
  logic [FRAME_BITS-1:0] shreg;
  logic                  rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
      rd_q    <= 1'b0;
      ta_bad  <= 1'b0;
      rd_word <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      idx    <= '0;
      shreg  <= frame;
      rd_q   <= is_read;
      ta_bad <= 1'b0;
    end else if (busy) begin
      if (rise_tk && rd_q) begin
        if (idx == TA_LO) ta_bad <= mdio_i;
        if (idx >= DAT0)  rd_word <= {rd_word[DATA_W-2:0], mdio_i};
      end
      if (fall_tk) begin
        if (idx == LAST) begin
          busy <= 1'b0;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign rd_done = busy && fall_tk && (idx == LAST) && rd_q;
  assign mdio_o  = busy ? shreg[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy && !(rd_q && (idx >= TA_HI));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  cmd_t              cmd_q;
  logic [DATA_W-1:0] adr_q, wdt_q, rdt_q;
  logic              fail_q;

  logic busy, rise_tk, fall_tk, rd_done, ta_bad;
  logic [DATA_W-1:0] rd_word;

  logic cmd_wr, go_req;
  cmd_t new_cmd;
  logic [DATA_W-1:0]     fld;
  logic [FRAME_BITS-1:0] frame_w;

  assign cmd_wr  = bus_wr && (bus_addr == OFS_CMD);
  assign go_req  = cmd_wr && bus_wdata[GO_BIT];
  assign new_cmd = cmd_t'(bus_wdata[GO_BIT-1:0]);
  assign fld     = frame_sends_addr(new_cmd) ? adr_q : wdt_q;
  assign frame_w = {{PRE_BITS{1'b1}}, new_cmd, 2'b10, fld};

  mdio_clkdiv #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .mdc     (mdc),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  mdio_frame_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (go_req),
    .frame   (frame_w),
    .is_read (frame_is_read(new_cmd)),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_done (rd_done),
    .rd_word (rd_word),
    .ta_bad  (ta_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      adr_q  <= '0;
      wdt_q  <= '0;
      rdt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      if (cmd_wr && !busy)                    cmd_q <= new_cmd;
      if (bus_wr && bus_addr == OFS_ADR)      adr_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_WDT)      wdt_q <= bus_wdata;
      if (rd_done) begin
        rdt_q  <= rd_word;
        fail_q <= ta_bad;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_CMD: bus_rdata <= {1'b0, busy, cmd_q};
        OFS_ADR: bus_rdata <= adr_q;
        OFS_WDT: bus_rdata <= wdt_q;
        OFS_RDT: bus_rdata <= rdt_q;
        OFS_STS: bus_rdata <= {{(DATA_W-1){1'b0}}, fail_q};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV = 10
) (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic go_req
);
  localparam int RW = $clog2(DIV) + 2;

  logic          mdc_q;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      run   <= '0;
    end else begin
      mdc_q <= mdc;
      if (!busy)              run <= '0;
      else if (mdc != mdc_q)  run <= RW'(1);
      else if (run != '1)     run <= run + 1'b1;
    end
  end

  // R1: idle bus is quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R3: a frame starts only from a command write carrying the start bit
  p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go_req));

  // R4: no MDC level lasts longer than half the divide ratio
  p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run <= RW'(DIV / 2)));

  // R5: master output holds while MDC is high
  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk #(.DIV(DIV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .busy    (busy),
  .go_req  (go_req)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int DIV = 4;
  localparam int FB  = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_en = 1'b0, phy_bit = 1'b1, phy_fail = 1'b0;
  logic [15:0] phy_data = '0;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_master #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_busy = 0, m_read = 0;
  int          m_cyc = 0;
  logic [63:0] m_frame = '0;
  logic [15:0] sh_adr = '0, sh_wdt = '0;

  function automatic bit read_kind(logic [15:0] c);
    return (c[13:12] == 2'd1 && c[11:10] == 2'd2) || (c[13:12] == 2'd0 && c[11:10] >= 2'd2);
  endfunction

  function automatic logic [63:0] exp_frame(logic [15:0] c, logic [15:0] a, logic [15:0] w);
    logic [15:0] d;
    d = (c[13:12] == 2'd0 && c[11:10] == 2'd0) ? a : w;
    return {32'hFFFF_FFFF, c[13:0], 2'b10, d};
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_busy) begin
        m_cyc++;
        if (m_cyc == FB * DIV) m_busy = 0;
      end else if (bus_wr && bus_addr == 5'h00 && bus_wdata[14]) begin
        m_busy  = 1;
        m_cyc   = 0;
        m_read  = read_kind(bus_wdata);
        m_frame = exp_frame(bus_wdata, sh_adr, sh_wdt);
      end
      if (bus_wr && bus_addr == 5'h04) sh_adr = bus_wdata;
      if (bus_wr && bus_addr == 5'h08) sh_wdt = bus_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_mdc, e_oe;
      e_mdc = m_busy && ((m_cyc % DIV) >= DIV / 2);
      e_oe  = m_busy && !(m_read && (m_cyc / DIV) >= 46);
      chk(mdc === e_mdc, "R4 mdc level", 64'(mdc), 64'(e_mdc));
      chk(mdio_oe === e_oe, "R7 mdio_oe", 64'(mdio_oe), 64'(e_oe));
      if (e_oe) chk(mdio_o === m_frame[63 - m_cyc / DIV], "R5 mdio_o bit",
                    64'(mdio_o), 64'(m_frame[63 - m_cyc / DIV]));
    end
  end

  // ---------------- line capture and PHY responder ----------------
  logic [63:0] cap = '0;
  int rises = 0;
  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_i};
    rises++;
  end

  always @(negedge mdc) begin
    int k;
    k = rises;
    phy_en  = m_read && !phy_fail && k >= 47 && k < 64;
    phy_bit = (k >= 48 && k < 64) ? phy_data[63 - k] : 1'b0;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    int g;
    g = 0;
    do begin bus_read(5'h00, v); g++; end while (v[14] && g < 5000);
  endtask

  function automatic logic [15:0] mk(logic [1:0] st, logic [1:0] op, logic [4:0] p, logic [4:0] dv);
    return {1'b0, 1'b1, st, op, p, dv};
  endfunction

  task automatic do_frame(input logic [15:0] c);
    rises = 0;
    bus_write(5'h00, c);
    wait_idle();
  endtask

  // ---------------- test sequence ----------------
  initial begin
    logic [15:0] v, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset", {mdc, mdio_oe}, 0);
    for (int a = 0; a < 5; a++) begin
      bus_read(5'(a * 4), v);
      chk(v == 16'h0, "R1 register reset value", v, 0);
    end

    // R2 holding registers
    bus_write(5'h04, 16'hABCD); bus_read(5'h04, v);
    chk(v == 16'hABCD, "R2 address readback", v, 16'hABCD);
    bus_write(5'h08, 16'h5A5A); bus_read(5'h08, v);
    chk(v == 16'h5A5A, "R2 write-data readback", v, 16'h5A5A);

    // R3 command without start bit stores fields, starts nothing
    rises = 0;
    bus_write(5'h00, 16'h0123);
    repeat (20) @(negedge clk);
    chk(rises == 0, "R3 no frame without start", rises, 0);
    bus_read(5'h00, v);
    chk(v == 16'h0123, "R3 stored fields", v, 16'h0123);

    // short write frame, with an ignored command during it (R10)
    c = mk(2'd1, 2'd1, 5'h11, 5'h0A);
    rises = 0;
    bus_write(5'h00, c);
    bus_read(5'h00, v);
    chk(v == c, "R3 start bit high while busy", v, c);
    bus_write(5'h00, mk(2'd0, 2'd3, 5'h1F, 5'h1F));
    bus_read(5'h00, v);
    chk(v == c, "R10 busy command ignored", v, c);
    wait_idle();
    bus_read(5'h00, v);
    chk(v == (c & 16'hBFFF), "R3 start bit clears", v, c & 16'hBFFF);
    chk(rises == 64, "R3 frame length", rises, 64);
    chk(cap == exp_frame(c, 16'hABCD, 16'h5A5A), "R5 R10 short write frame", cap, exp_frame(c, 16'hABCD, 16'h5A5A));
    chk(cap[17:0] == {2'b10, 16'h5A5A}, "R6 write field and turnaround", cap[17:0], {2'b10, 16'h5A5A});

    // extended address frame
    bus_write(5'h04, 16'hBEEF);
    c = mk(2'd0, 2'd0, 5'h03, 5'h07);
    do_frame(c);
    chk(cap[15:0] == 16'hBEEF, "R6 address frame field", cap[15:0], 16'hBEEF);
    chk(cap == exp_frame(c, 16'hBEEF, 16'h5A5A), "R5 extended address frame", cap, exp_frame(c, 16'hBEEF, 16'h5A5A));

    // extended write frame
    c = mk(2'd0, 2'd1, 5'h03, 5'h07);
    do_frame(c);
    chk(cap[15:0] == 16'h5A5A, "R6 extended write field", cap[15:0], 16'h5A5A);

    // short read
    phy_data = 16'hC3A5; phy_fail = 1'b0;
    c = mk(2'd1, 2'd2, 5'h02, 5'h01);
    do_frame(c);
    bus_read(5'h0C, v);
    chk(v == 16'hC3A5, "R8 short read data", v, 16'hC3A5);
    bus_read(5'h10, v);
    chk(v == 16'h0, "R9 good turnaround status", v, 0);
    chk(cap == {32'hFFFF_FFFF, c[13:0], 2'b10, 16'hC3A5}, "R7 read line content", cap,
        {32'hFFFF_FFFF, c[13:0], 2'b10, 16'hC3A5});

    // failed read: PHY silent
    phy_fail = 1'b1;
    do_frame(c);
    bus_read(5'h10, v);
    chk(v == 16'h1, "R9 missing turnaround flagged", v, 1);
    chk(cap[17:16] == 2'b11, "R9 turnaround left high", cap[17:16], 2'b11);

    // write frame leaves the flag alone
    phy_fail = 1'b0;
    do_frame(mk(2'd0, 2'd1, 5'h04, 5'h01));
    bus_read(5'h10, v);
    chk(v == 16'h1, "R9 flag kept over write frame", v, 1);

    // extended read, op 3
    phy_data = 16'h0F0F;
    do_frame(mk(2'd0, 2'd3, 5'h1E, 5'h03));
    bus_read(5'h0C, v);
    chk(v == 16'h0F0F, "R8 extended read data", v, 16'h0F0F);
    bus_read(5'h10, v);
    chk(v == 16'h0, "R9 flag cleared by good read", v, 0);

    // extended read with post-increment, op 2
    phy_data = 16'h8001;
    do_frame(mk(2'd0, 2'd2, 5'h00, 5'h1F));
    bus_read(5'h0C, v);
    chk(v == 16'h8001, "R7 R8 post-increment read data", v, 16'h8001);

    repeat (10) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle after frames", {mdc, mdio_oe}, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule